// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block decides, for a small accumulator CPU, whether the next thing the core does is interrupt entry or the next instruction. Six maskable hardware request lines and a software-interrupt opcode strobe feed it. Nothing is decided while an instruction is executing. When the core signals that an instruction has completed, the arbiter looks at everything pending at that moment. If there is a winner it emits a one-cycle take strobe with the winner's index. On that same edge it sets the global interrupt mask, and it keeps the previous mask value in a one-deep save register.

Hardware requests are level-sensitive. The arbiter never clears them, so the interrupt handler has to quiet its source. A software interrupt is latched when its opcode strobe is seen, is taken at the next boundary even while the mask is set, and is dropped once it has been taken. A return strobe copies the saved mask value back. A direct mask write lets software set or clear the mask, for example to allow one level of nesting inside a handler. Stack handling and the vector fetch belong to the core.

Top module: `irq_boundary_arb`

## Requirements
- R1: After reset, takeIrq is 0, takeIdx is 0 and maskBit is 1 (interrupts masked), and no software interrupt is pending.
- R2: Index encoding on takeIdx: 0 is the software interrupt, and hwReq[i] maps to i+1 (so 1..6). takeIdx is 0 in every cycle where takeIrq is 0.
- R3: Requests are evaluated only in a cycle where instrDone is 1. takeIrq is 1 in the cycle after that boundary and lasts one cycle.
- R4: A hardware source is taken only when maskBit is 0 and both its hwReq and hwEnable bits are 1. Otherwise no entry occurs.
- R5: On entry, maskBit becomes 1 and the value maskBit had before entry is saved.
- R6: An rtiOp cycle with no entry in the same cycle loads maskBit from the saved value.
- R7: When several sources are eligible at one boundary, the winner follows a fixed priority: the software interrupt first, then hwReq[0], hwReq[1], and so on up to hwReq[5].
- R8: The software interrupt is latched on swiOp. It is taken at the next boundary (which may be the same cycle) regardless of maskBit, and it is cleared when taken.
- R9: Hardware requests are not latched. A request removed before the boundary is not taken.
- R10: maskWrEn loads maskWrVal into maskBit. Entry takes precedence over rtiOp, and rtiOp takes precedence over a write. The save register is one entry deep, so a nested entry overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | 6 | Level-sensitive hardware request lines |
| hwEnable | input | 6 | Per-source enable bits |
| instrDone | input | 1 | Instruction-complete strobe (boundary) |
| swiOp | input | 1 | Software-interrupt opcode strobe |
| rtiOp | input | 1 | Return-from-interrupt strobe |
| maskWrEn | input | 1 | Direct write of the global mask |
| maskWrVal | input | 1 | Value for the direct mask write |
| takeIrq | output | 1 | One-cycle interrupt-entry strobe |
| takeIdx | output | 3 | Winning source index |
| maskBit | output | 1 | Global interrupt mask |

## Verification
The hardest state to reach is a nested entry. Software must first clear the mask inside a running handler, then a second source must win. That overwrites the one-deep save register, so both returns afterwards must yield the mask value seen at the nested entry. The stimulus reaches this by a taken entry, a mask write of 0, a second boundary with a different enabled source, and two return strobes in a row. Separate sequences place a return strobe and a boundary in the same cycle, and a latched software interrupt against an active mask.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int HW_SRC = 6;
  localparam int IDX_W  = $clog2(HW_SRC + 1);
  localparam logic [IDX_W-1:0] SWI_IDX = '0;

  // Strobes from the control decision into the state-holding datapath
  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] idx;
    logic             restore;
    logic             write;
  } arbCtrl_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic [HW_SRC-1:0] hwReq,
  input  logic [HW_SRC-1:0] hwEnable,
  input  logic              instrDone,
  input  logic              swiOp,
  input  logic              swiPend,
  input  logic              maskQ,
  input  logic              rtiOp,
  input  logic              maskWrEn,
  output arbCtrl_t          ctrl
);
  logic [HW_SRC-1:0] eligible;
  logic [IDX_W-1:0]  hwIdx;
  logic              swiLive;
  logic              takeNow;

  assign eligible = hwReq & hwEnable & {HW_SRC{~maskQ}};
  assign swiLive  = swiPend | swiOp;

  // lowest bit wins among hardware sources
  always_comb begin
    hwIdx = '0;
    for (int i = HW_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) hwIdx = IDX_W'(i + 1);
    end
  end

  assign takeNow = instrDone && (swiLive || (|eligible));

  always_comb begin
    ctrl.take    = takeNow;
    ctrl.idx     = swiLive ? SWI_IDX : hwIdx;
    ctrl.restore = rtiOp && !takeNow;
    ctrl.write   = maskWrEn && !takeNow && !rtiOp;
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  arbCtrl_t         ctrl,
  input  logic             swiOp,
  input  logic             maskWrVal,
  output logic             swiPend,
  output logic             maskQ,
  output logic             takeQ,
  output logic [IDX_W-1:0] idxQ
);
  logic savedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swiPend <= 1'b0;
      maskQ   <= 1'b1;
      savedQ  <= 1'b1;
      takeQ   <= 1'b0;
      idxQ    <= '0;
    end else begin
      takeQ <= ctrl.take;
      idxQ  <= ctrl.take ? ctrl.idx : '0;
      if (ctrl.take) begin
        savedQ <= maskQ;
        maskQ  <= 1'b1;
      end else if (ctrl.restore) begin
        maskQ <= savedQ;
      end else if (ctrl.write) begin
        maskQ <= maskWrVal;
      end
      if (ctrl.take && ctrl.idx == SWI_IDX) swiPend <= 1'b0;
      else if (swiOp)                       swiPend <= 1'b1;
    end
  end

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.take && !ctrl.restore && !ctrl.write) |=> $stable(maskQ)); // R10
  AST_RTI_LOADS_SAVED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restore |=> (maskQ == $past(savedQ))); // R6
endmodule

// File: rtl/irq_boundary_arb.sv
module irq_boundary_arb
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HW_SRC-1:0] hwReq,
  input  logic [HW_SRC-1:0] hwEnable,
  input  logic              instrDone,
  input  logic              swiOp,
  input  logic              rtiOp,
  input  logic              maskWrEn,
  input  logic              maskWrVal,
  output logic              takeIrq,
  output logic [IDX_W-1:0]  takeIdx,
  output logic              maskBit
);
  arbCtrl_t ctrl;
  logic     swiPend;

  irq_arb_ctrl u_ctrl (
    .hwReq(hwReq), .hwEnable(hwEnable), .instrDone(instrDone),
    .swiOp(swiOp), .swiPend(swiPend), .maskQ(maskBit),
    .rtiOp(rtiOp), .maskWrEn(maskWrEn), .ctrl(ctrl)
  );

  irq_arb_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .swiOp(swiOp),
    .maskWrVal(maskWrVal), .swiPend(swiPend), .maskQ(maskBit),
    .takeQ(takeIrq), .idxQ(takeIdx)
  );

  // one-hot of the hardware source reported on takeIdx (for checks)
  logic [HW_SRC-1:0] takenBit;
  logic [HW_SRC-1:0] liveReq;
  assign takenBit = HW_SRC'(1) << (takeIdx - IDX_W'(1));
  assign liveReq  = hwReq & hwEnable;

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrDone)); // R3
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (takeIdx == '0)); // R2
  AST_HW_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeIdx != SWI_IDX) |-> !$past(maskBit)); // R4
  AST_HW_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeIdx != SWI_IDX) |-> |($past(liveReq) & takenBit)); // R4
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> maskBit); // R5
  AST_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeIdx != SWI_IDX) |-> (($past(liveReq) & (takenBit - HW_SRC'(1))) == '0)); // R7
  AST_SWI_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(swiOp && instrDone) |-> (takeIrq && takeIdx == SWI_IDX)); // R8
endmodule

// File: tb/irq_boundary_arb_tb.sv
module irq_boundary_arb_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] hwReq, hwEnable;
  logic       instrDone, swiOp, rtiOp, maskWrEn, maskWrVal;
  logic       takeIrq, maskBit;
  logic [2:0] takeIdx;

  irq_boundary_arb u_dut (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .hwEnable(hwEnable),
    .instrDone(instrDone), .swiOp(swiOp), .rtiOp(rtiOp),
    .maskWrEn(maskWrEn), .maskWrVal(maskWrVal),
    .takeIrq(takeIrq), .takeIdx(takeIdx), .maskBit(maskBit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       take;
    logic [2:0] idx;
    logic       mask;
    int         due;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  nRun = 0, nFail = 0;
  bit  done = 0;
  logic mMask, mSaved, mSwi;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare results as they become due
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t e;
      e = expQ.pop_front();
      nRun++;
      if (takeIrq !== e.take || takeIdx !== e.idx || maskBit !== e.mask) begin
        nFail++;
        $display("FAIL %s: take/idx/mask got %b/%0d/%b expected %b/%0d/%b",
                 e.tag, takeIrq, takeIdx, maskBit, e.take, e.idx, e.mask);
      end
    end
  end

  // driver: one cycle of stimulus plus its predicted outcome
  task automatic step(input logic [5:0] req, input logic [5:0] en, input logic bnd,
                      input logic swi, input logic rti, input logic wr, input logic wv,
                      input string tag);
    logic [5:0] elig;
    logic       swiNow, tk;
    logic [2:0] ix;
    expItem_t   e;
    hwReq = req; hwEnable = en; instrDone = bnd; swiOp = swi;
    rtiOp = rti; maskWrEn = wr; maskWrVal = wv;
    elig   = req & en & {6{~mMask}};
    swiNow = mSwi | swi;
    tk = bnd && (swiNow || elig != 0);
    ix = 3'd0;
    if (tk && !swiNow) begin
      for (int i = 5; i >= 0; i--) if (elig[i]) ix = 3'(i + 1);
    end
    if (tk) begin mSaved = mMask; mMask = 1'b1; end
    else if (rti) mMask = mSaved;
    else if (wr) mMask = wv;
    mSwi = (tk && ix == 3'd0) ? 1'b0 : swiNow;
    e.take = tk; e.idx = tk ? ix : 3'd0; e.mask = mMask; e.due = cyc + 1; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; hwReq = '0; hwEnable = '0; instrDone = 0; swiOp = 0;
    rtiOp = 0; maskWrEn = 0; maskWrVal = 0;
    mMask = 1'b1; mSaved = 1'b1; mSwi = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nRun++;
    if (takeIrq !== 1'b0 || takeIdx !== 3'd0 || maskBit !== 1'b1) begin
      nFail++;
      $display("FAIL R1: reset take/idx/mask got %b/%0d/%b expected 0/0/1", takeIrq, takeIdx, maskBit);
    end
    step(6'h01, 6'h01, 1, 0, 0, 0, 0, "R4 masked at reset");
    step(6'h00, 6'h00, 0, 0, 0, 1, 0, "R10 write clears mask");
    step(6'h01, 6'h01, 0, 0, 0, 0, 0, "R3 no boundary");
    step(6'h01, 6'h01, 1, 0, 0, 0, 0, "R5 entry");
    step(6'h01, 6'h01, 0, 0, 0, 0, 0, "R3 single pulse");
    step(6'h00, 6'h00, 0, 0, 1, 0, 0, "R6 return restores");
    step(6'h04, 6'h3B, 1, 0, 0, 0, 0, "R4 disabled source");
    step(6'h02, 6'h3F, 0, 0, 0, 0, 0, "R9 request raised");
    step(6'h00, 6'h3F, 1, 0, 0, 0, 0, "R9 request gone");
    for (int k = 0; k < 6; k++) begin
      step(6'h3F << k, 6'h3F, 1, 0, 0, 0, 0, "R7 hardware order");
      step(6'h00, 6'h00, 0, 0, 1, 0, 0, "R6 return in walk");
    end
    step(6'h00, 6'h00, 0, 0, 0, 1, 1, "R10 write sets mask");
    step(6'h00, 6'h00, 0, 1, 0, 0, 0, "R8 swi latched");
    step(6'h3F, 6'h3F, 1, 0, 0, 0, 0, "R8 swi while masked");
    step(6'h00, 6'h00, 1, 0, 0, 0, 0, "R8 swi cleared after take");
    step(6'h00, 6'h00, 0, 0, 1, 0, 0, "R6 return to masked");
    step(6'h00, 6'h00, 0, 0, 0, 1, 0, "R10 unmask");
    step(6'h01, 6'h01, 1, 1, 0, 0, 0, "R7 swi beats hardware");
    step(6'h01, 6'h01, 0, 0, 1, 0, 0, "R6 return after swi");
    step(6'h01, 6'h01, 1, 0, 0, 0, 0, "R2 hardware index after swi");
    step(6'h00, 6'h00, 0, 0, 0, 1, 0, "R10 unmask inside handler");
    step(6'h02, 6'h02, 1, 0, 0, 0, 0, "R10 nested entry");
    step(6'h00, 6'h00, 0, 0, 1, 0, 0, "R10 first return");
    step(6'h00, 6'h00, 0, 0, 1, 0, 0, "R10 second return one deep");
    step(6'h01, 6'h01, 1, 0, 1, 0, 0, "R10 entry over return");
    step(6'h00, 6'h00, 0, 0, 1, 1, 1, "R10 return over write");
    step(6'h00, 6'h00, 0, 0, 0, 0, 0, "R2 idle index");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule